// File: doc/BRIEF.md
# Paged Virtual Address Relocation Unit

This block sits between a 16-bit processor and a wider physical memory. Every virtual address is split into a three-bit page number and a 13-bit offset. The page number picks one of eight page registers in one of two banks: one bank serves the privileged (kernel) mode and the other serves the unprivileged (user) mode. The physical address is the selected page base, shifted left by six bits, plus the offset.

Both banks are software-visible. Each page has a base register and a descriptor register, and all of them sit at fixed addresses in the top 8 KiB of the virtual space, which is the I/O window. Addresses in that window are decoded as registers and are never relocated. A read-only status word in the same window reports the current mode and the page that holds the program counter. On every store to memory, the unit sets a "written" flag in the descriptor of the page that the store went through. The processor supplies the mode fields of its status word and a flag that asks for translation under the previous mode instead of the current one.

Top module: `page_reloc_unit`

## Requirements
- R1: The physical address equals (selected page base × 64) + vaddr[12:0], taken modulo 2^22. The page index is vaddr[15:13].
- R2: The mode is user only when the chosen 2-bit mode field is 2'b11. The chosen field is `prev_mode` when `use_prev` is 1 and `cur_mode` otherwise. Every other field value (00, 01, 10) is kernel.
- R3: User mode translates through the user bank. Kernel mode translates through the kernel bank.
- R4: A read (`acc_we`=0) of a virtual address below 1024 always translates through the kernel bank, in any mode. A write below 1024 follows the chosen mode.
- R5: `io_sel` is 1 exactly when vaddr >= octal 160000. While it is 1, `paddr` is 0 and no descriptor is marked.
- R6: The register windows are: kernel descriptors at octal 172300–172316, kernel bases at octal 172340–172356, user descriptors at octal 177600–177616 and user bases at octal 177640–177656. The page index is vaddr[3:1]. A word write (`acc_valid`=1, `acc_we`=1, `acc_byte`=0) loads all 16 bits at the next clock edge. Nothing is written while `acc_valid` is 0.
- R7: A byte write (`acc_byte`=1) to a page register leaves that register unchanged.
- R8: A memory write (`acc_valid`=1, `acc_we`=1, `io_sel`=0) sets bit 6 of the descriptor in the same bank and at the same index that the translation used, and keeps the other bits.
- R9: Register reads are combinational. `rd_hit` is 1 and `rdata` holds the value in the same cycle. An I/O address that matches no register gives `rd_hit`=0 and `rdata`=0.
- R10: A read of octal 177572 returns the status word. Bits 6:5 are 2'b11 when `cur_mode` is 2'b11 and 2'b00 otherwise. Bits 3:1 are `pc_page`. All other bits are 0.
- R11: A synchronous active-low reset clears all 32 page registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vaddr | input | 16 | Virtual address |
| acc_valid | input | 1 | Access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| wdata | input | 16 | Write data for page registers |
| cur_mode | input | 2 | Current mode field of the status word |
| prev_mode | input | 2 | Previous mode field of the status word |
| use_prev | input | 1 | Translate under the previous mode |
| pc_page | input | 3 | Bits 15:13 of the program counter |
| paddr | output | 22 | Physical address |
| io_sel | output | 1 | Address lies in the I/O window |
| rd_hit | output | 1 | A readable register is addressed |
| rdata | output | 16 | Register read data |

## Verification
Each page base is loaded with a distinct value. Translations are then run under these cases, so that a wrong bank or a wrong index shows up as a wrong address:
- kernel and user current modes;
- the previous mode chosen over a differing current mode;
- supervisor-like codes 01 and 10;
- reads and writes on both sides of the 1024 vector limit.

Stores are then followed by descriptor read-back. This tells apart marking in the correct bank, marking in the other bank, and a mark that disturbs other bits.

Directed cases cover:
- a base of all ones, to show the wrap at 22 bits;
- the boundary of the I/O window;
- byte writes and writes without the strobe;
- the status word under each mode;
- an unmapped I/O read.

// File: rtl/pru_pkg.sv
// Package: shared sizes and fixed addresses for the relocation unit.
// Assumes a 16-bit virtual space split into 8 pages of 8 KiB.
package pru_pkg;
    localparam int VA_W     = 16;
    localparam int PAGE_CNT = 8;
    localparam int PAR_W    = 16;
    localparam int PA_W     = 22;
    localparam int OFS_W    = 13;
    localparam int PG_SH    = 6;
    localparam int VEC_LIM  = 1024;

    localparam logic [15:0] IO_BASE  = 16'o160000;
    localparam logic [15:0] KDSC_BASE = 16'o172300;
    localparam logic [15:0] KBAS_BASE = 16'o172340;
    localparam logic [15:0] UDSC_BASE = 16'o177600;
    localparam logic [15:0] UBAS_BASE = 16'o177640;
    localparam logic [15:0] STAT_ADDR = 16'o177572;
    localparam int          MARK_BIT  = 6;
endpackage

// File: rtl/pru_io_decode.sv
// Module: pru_io_decode
// Decodes the I/O window and the page-register and status addresses.
// Assumes the register windows are aligned to 2*PAGE_CNT bytes.
module pru_io_decode
    import pru_pkg::*;
#(
    parameter int VAW   = VA_W,
    parameter int PAGES = PAGE_CNT,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic [VAW-1:0]   vaddr,
    output logic             io_sel,
    output logic             reg_hit,
    output logic             reg_is_base,
    output logic             reg_user,
    output logic [IDX_W-1:0] reg_idx,
    output logic             stat_hit
);
    localparam int HI = VAW - 1;
    localparam int LO = IDX_W + 1;

    logic hit_kd, hit_kb, hit_ud, hit_ub;

    // Compare the upper address bits against each register window.
    always_comb begin
        io_sel   = (vaddr >= IO_BASE[VAW-1:0]);
        hit_kd   = (vaddr[HI:LO] == KDSC_BASE[HI:LO]);
        hit_kb   = (vaddr[HI:LO] == KBAS_BASE[HI:LO]);
        hit_ud   = (vaddr[HI:LO] == UDSC_BASE[HI:LO]);
        hit_ub   = (vaddr[HI:LO] == UBAS_BASE[HI:LO]);
        stat_hit = (vaddr == STAT_ADDR[VAW-1:0]);
        reg_hit     = hit_kd | hit_kb | hit_ud | hit_ub;
        reg_is_base = hit_kb | hit_ub;
        reg_user    = hit_ud | hit_ub;
        reg_idx     = vaddr[IDX_W:1];
    end
endmodule

// File: rtl/pru_xlate.sv
// Module: pru_xlate
// Picks the translation bank from the mode fields and forms the physical address.
// Assumes mode code 2'b11 is user and every other code is kernel.
module pru_xlate
    import pru_pkg::*;
#(
    parameter int VAW   = VA_W,
    parameter int PAGES = PAGE_CNT,
    parameter int PARW  = PAR_W,
    parameter int PAW   = PA_W,
    parameter int OFSW  = OFS_W,
    parameter int SH    = PG_SH,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic [VAW-1:0]  vaddr,
    input  logic            is_write,
    input  logic            io_sel,
    input  logic [1:0]      cur_mode,
    input  logic [1:0]      prev_mode,
    input  logic            use_prev,
    input  logic [PARW-1:0] base,
    output logic [IDX_W:0]  xl_sel,
    output logic [PAW-1:0]  paddr
);
    logic [1:0]     mode_fld;
    logic           user_bank;
    logic [PAW-1:0] base_sh;
    logic [PAW-1:0] ofs_ext;

    // Choose the mode field, then apply the vector-area override for reads.
    always_comb begin
        mode_fld  = use_prev ? prev_mode : cur_mode;
        user_bank = (mode_fld == 2'b11);
        if (!is_write && (vaddr < VAW'(VEC_LIM)))
            user_bank = 1'b0;
        xl_sel = {user_bank, vaddr[VAW-1 -: IDX_W]};
    end

    // Relocate: shifted page base plus in-page offset, wrapping at PAW bits.
    always_comb begin
        base_sh = PAW'(base) << SH;
        ofs_ext = PAW'(vaddr[OFSW-1:0]);
        paddr   = io_sel ? '0 : (base_sh + ofs_ext);
    end
endmodule

// File: rtl/pru_page_bank.sv
// Module: pru_page_bank
// Holds the base and descriptor registers of both banks (kernel first, then user).
// Assumes the register write and the written-mark never occur in the same cycle.
module pru_page_bank
    import pru_pkg::*;
#(
    parameter int PAGES = PAGE_CNT,
    parameter int PARW  = PAR_W,
    parameter int MBIT  = MARK_BIT,
    localparam int IDX_W = $clog2(PAGES),
    localparam int NREG  = 2 * PAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic            reg_is_base,
    input  logic [IDX_W:0]  reg_sel,
    input  logic [PARW-1:0] wdata,
    input  logic            mark_we,
    input  logic [IDX_W:0]  xl_sel,
    output logic [PARW-1:0] rd_data,
    output logic [PARW-1:0] xl_base
);
    logic [PARW-1:0] base_q [NREG];
    logic [PARW-1:0] dsc_q  [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_page
        // Base register: reset, or load on a matching word write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[i] <= '0;
            else if (reg_we && reg_is_base && (reg_sel == (IDX_W+1)'(i)))
                base_q[i] <= wdata;
        end

        // Descriptor register: reset, load on write, or set the written bit on a store.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dsc_q[i] <= '0;
            else if (reg_we && !reg_is_base && (reg_sel == (IDX_W+1)'(i)))
                dsc_q[i] <= wdata;
            else if (mark_we && (xl_sel == (IDX_W+1)'(i)))
                dsc_q[i][MBIT] <= 1'b1;
        end
    end

    // Read and translation lookups.
    always_comb begin
        rd_data = reg_is_base ? base_q[reg_sel] : dsc_q[reg_sel];
        xl_base = base_q[xl_sel];
    end

    logic           mark_d;
    logic [IDX_W:0] mark_sel_d;

    // Remember the last store so the mark can be checked one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_d     <= 1'b0;
            mark_sel_d <= '0;
        end else begin
            mark_d     <= mark_we;
            mark_sel_d <= xl_sel;
        end
    end

    // A store must leave the written bit set in the page it used.
    always_ff @(posedge clk) begin
        if (rst_n && mark_d)
            assert_mark_set_R8: assert (dsc_q[mark_sel_d][MBIT])
                else $error("written bit not set");
    end

    assert_one_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && mark_we));
endmodule

// File: rtl/page_reloc_unit.sv
// Module: page_reloc_unit (top)
// Relocates 16-bit virtual addresses through two banks of page registers and
// exposes those registers plus a status word in the I/O window.
// Assumes the caller holds the inputs stable for the whole cycle of an access.
module page_reloc_unit
    import pru_pkg::*;
#(
    parameter int VAW   = VA_W,
    parameter int PAGES = PAGE_CNT,
    parameter int PARW  = PAR_W,
    parameter int PAW   = PA_W,
    localparam int IDX_W = $clog2(PAGES),
    localparam int PGW   = VAW - OFS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VAW-1:0]  vaddr,
    input  logic            acc_valid,
    input  logic            acc_we,
    input  logic            acc_byte,
    input  logic [PARW-1:0] wdata,
    input  logic [1:0]      cur_mode,
    input  logic [1:0]      prev_mode,
    input  logic            use_prev,
    input  logic [PGW-1:0]  pc_page,
    output logic [PAW-1:0]  paddr,
    output logic            io_sel,
    output logic            rd_hit,
    output logic [PARW-1:0] rdata
);
    logic             reg_hit, reg_is_base, reg_user, stat_hit;
    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W:0]   xl_sel;
    logic [PARW-1:0]  bank_rd, xl_base, stat_word;
    logic             reg_we, mark_we;

    pru_io_decode #(.VAW(VAW), .PAGES(PAGES)) u_dec (
        .vaddr       (vaddr),
        .io_sel      (io_sel),
        .reg_hit     (reg_hit),
        .reg_is_base (reg_is_base),
        .reg_user    (reg_user),
        .reg_idx     (reg_idx),
        .stat_hit    (stat_hit)
    );

    pru_xlate #(.VAW(VAW), .PAGES(PAGES), .PARW(PARW), .PAW(PAW)) u_xl (
        .vaddr     (vaddr),
        .is_write  (acc_we),
        .io_sel    (io_sel),
        .cur_mode  (cur_mode),
        .prev_mode (prev_mode),
        .use_prev  (use_prev),
        .base      (xl_base),
        .xl_sel    (xl_sel),
        .paddr     (paddr)
    );

    // Qualify strobes: word-only register writes, stores outside the I/O window.
    always_comb begin
        reg_we  = acc_valid && acc_we && !acc_byte && reg_hit;
        mark_we = acc_valid && acc_we && !io_sel;
    end

    pru_page_bank #(.PAGES(PAGES), .PARW(PARW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_is_base (reg_is_base),
        .reg_sel     ({reg_user, reg_idx}),
        .wdata       (wdata),
        .mark_we     (mark_we),
        .xl_sel      (xl_sel),
        .rd_data     (bank_rd),
        .xl_base     (xl_base)
    );

    // Build the status word and multiplex read data.
    always_comb begin
        stat_word      = '0;
        stat_word[6:5] = (cur_mode == 2'b11) ? 2'b11 : 2'b00;
        stat_word[PGW:1] = pc_page;
        rd_hit = stat_hit | reg_hit;
        if (stat_hit)     rdata = stat_word;
        else if (reg_hit) rdata = bank_rd;
        else              rdata = '0;
    end

    assert_vec_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_we && (vaddr < VAW'(VEC_LIM))) |-> (xl_sel[IDX_W] == 1'b0));

    assert_io_no_reloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (paddr == '0));

    assert_byte_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && acc_byte) |-> !u_bank.reg_we);

    assert_stat_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && cur_mode == 2'b11) |-> (rdata[6:5] == 2'b11));
endmodule

// File: tb/sim_page_reloc_unit.sv
module sim_page_reloc_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] vaddr = 0;
    logic        acc_valid = 0, acc_we = 0, acc_byte = 0, use_prev = 0;
    logic [15:0] wdata = 0;
    logic [1:0]  cur_mode = 0, prev_mode = 0;
    logic [2:0]  pc_page = 0;
    logic [21:0] paddr;
    logic        io_sel, rd_hit;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [15:0] mbase [16];
    logic [15:0] mdsc  [16];

    page_reloc_unit u0 (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .acc_valid(acc_valid),
        .acc_we(acc_we), .acc_byte(acc_byte), .wdata(wdata),
        .cur_mode(cur_mode), .prev_mode(prev_mode), .use_prev(use_prev),
        .pc_page(pc_page), .paddr(paddr), .io_sel(io_sel),
        .rd_hit(rd_hit), .rdata(rdata)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] reg_addr(input bit user, input bit is_base, input int idx);
        logic [15:0] b;
        if (user) b = is_base ? 16'o177640 : 16'o177600;
        else      b = is_base ? 16'o172340 : 16'o172300;
        return b + 16'(idx * 2);
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [15:0] d, input bit bt, input bit vld);
        @(negedge clk);
        vaddr = a; wdata = d; acc_we = 1; acc_byte = bt; acc_valid = vld;
        @(negedge clk);
        acc_valid = 0; acc_we = 0; acc_byte = 0;
    endtask

    task automatic put_reg(input bit user, input bit is_base, input int idx, input logic [15:0] d);
        reg_write(reg_addr(user, is_base, idx), d, 1'b0, 1'b1);
        if (is_base) mbase[idx + 8 * int'(user)] = d;
        else         mdsc[idx + 8 * int'(user)]  = d;
    endtask

    task automatic read_chk(input logic [15:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        vaddr = a; acc_valid = 0; acc_we = 0;
        #2;
        chk(rd_hit === 1'b1 && rdata === exp, req, {15'b0, rd_hit, rdata}, {16'h0001, exp});
    endtask

    task automatic check_all_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            read_chk(reg_addr(i >= 8, 1'b1, i % 8), mbase[i], req);
            read_chk(reg_addr(i >= 8, 1'b0, i % 8), mdsc[i], req);
        end
    endtask

    // {vaddr[15:0], cur[1:0], prev[1:0], use_prev, we, byte}
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {16'o020004, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
        {16'o140777, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0},
        {16'o060010, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0},
        {16'o100000, 2'b00, 2'b11, 1'b1, 1'b0, 1'b0},
        {16'o000400, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0},
        {16'o001776, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0},
        {16'o002000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0},
        {16'o000100, 2'b11, 2'b00, 1'b0, 1'b1, 1'b0},
        {16'o040002, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0},
        {16'o157777, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1},
        {16'o120000, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1},
        {16'o077777, 2'b00, 2'b11, 1'b1, 1'b1, 1'b0}
    };

    function automatic logic [21:0] model_pa(input logic [15:0] va, input logic [1:0] cm,
                                             input logic [1:0] pm, input bit up, input bit we,
                                             output int sel);
        bit usr;
        usr = ((up ? pm : cm) == 2'b11);
        if (!we && va < 16'd1024) usr = 0;
        sel = int'(va[15:13]) + (usr ? 8 : 0);
        return 22'(({6'b0, mbase[sel], 6'b0}) + {15'b0, va[12:0]});
    endfunction

    initial begin
        int sel;
        logic [21:0] exp;
        for (int i = 0; i < 16; i++) begin mbase[i] = 0; mdsc[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11: everything zero after reset
        check_all_regs("R11");

        // R6: load every register through its window
        for (int i = 0; i < 8; i++) begin
            put_reg(1'b0, 1'b1, i, 16'h0040 * 16'(i + 1));
            put_reg(1'b1, 1'b1, i, 16'h1000 + 16'h0123 * 16'(i));
        end
        put_reg(1'b0, 1'b0, 2, 16'h7f06);
        put_reg(1'b1, 1'b0, 5, 16'h0001);
        check_all_regs("R6");

        // R1 R2 R3 R4 R8: table of translations and stores
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {vaddr, cur_mode, prev_mode, use_prev, acc_we, acc_byte} = VEC[v];
            acc_valid = 1;
            exp = model_pa(VEC[v][22:7], VEC[v][6:5], VEC[v][4:3], VEC[v][2], VEC[v][1], sel);
            #2;
            chk(paddr === exp && io_sel === 1'b0, "R1 R2 R3 R4 translation", {10'b0, paddr}, {10'b0, exp});
            if (VEC[v][1]) mdsc[sel] = mdsc[sel] | 16'h0040;
            @(negedge clk);
            acc_valid = 0; acc_we = 0; acc_byte = 0; use_prev = 0;
        end
        cur_mode = 0; prev_mode = 0;
        // R8: written bits in the right bank, other bits kept
        check_all_regs("R8");

        // R1: wrap at 22 bits
        put_reg(1'b0, 1'b1, 6, 16'hffff);
        @(negedge clk);
        vaddr = 16'o157777; cur_mode = 0;
        #2;
        chk(paddr === 22'h001fbf, "R1 wrap", {10'b0, paddr}, 32'h001fbf);

        // R5: I/O window boundary
        @(negedge clk); vaddr = 16'o157777; #2;
        chk(io_sel === 1'b0, "R5 below window", {31'b0, io_sel}, 0);
        @(negedge clk); vaddr = 16'o160000; #2;
        chk(io_sel === 1'b1 && paddr === 0, "R5 window start", {9'b0, io_sel, paddr}, 32'h00400000);
        // R5: store into unmapped I/O marks nothing
        reg_write(16'o170000, 16'h1234, 1'b0, 1'b1);
        check_all_regs("R5 no mark");

        // R7: byte write to a base register ignored
        reg_write(reg_addr(1'b0, 1'b1, 1), 16'h5555, 1'b1, 1'b1);
        read_chk(reg_addr(1'b0, 1'b1, 1), mbase[1], "R7");
        // R6: write without strobe ignored
        reg_write(reg_addr(1'b1, 1'b0, 3), 16'haaaa, 1'b0, 1'b0);
        read_chk(reg_addr(1'b1, 1'b0, 3), mdsc[11], "R6 no strobe");

        // R10: status word
        cur_mode = 2'b11; pc_page = 3'd5;
        read_chk(16'o177572, 16'h006a, "R10 user");
        cur_mode = 2'b01; pc_page = 3'd2;
        read_chk(16'o177572, 16'h0004, "R10 kernel");
        cur_mode = 2'b00;

        // R9: unmapped I/O read
        @(negedge clk); vaddr = 16'o177000; #2;
        chk(rd_hit === 1'b0 && rdata === 0, "R9 unmapped", {15'b0, rd_hit, rdata}, 0);

        // R11: reset again clears registers
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 16; i++) begin mbase[i] = 0; mdsc[i] = 0; end
        check_all_regs("R11 again");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule